// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block keeps a small set of recent page translations. Each entry pairs a virtual page number with a physical frame number and three status flags: modified, recently used and present in memory. A lookup compares the page number of the incoming virtual address against every entry at the same time, with one comparator per entry. In the same cycle it returns either a physical address or a miss. The low offset bits are copied through unchanged. A matching entry whose page is not present raises a fault and returns no address.

After a miss, the surrounding logic reads the page table and writes the translation through the fill port, then retries the access. The fill logic never creates two entries with the same key. It picks the target slot in this order:

1. the entry that already holds the same page,
2. otherwise the lowest-numbered empty slot,
3. otherwise the slot named by a free-running pseudo-random pointer.

A flush input empties the whole buffer in one cycle.

Top module: `fa_tlb`

## Requirements
- R1: After reset, and in the cycle after `flush_i` is high, every entry is empty, so any lookup reports a miss.
- R2: A lookup that matches an entry present in memory raises `hit_o` in the same cycle as `lkp_valid_i`. It drives `paddr_o` with the frame number in bits 15:10 and the virtual address bits 9:0 in bits 9:0.
- R3: A lookup with no matching entry raises `miss_o` only, and `paddr_o` is zero. Exactly one of `hit_o`, `miss_o` and `fault_o` is high while `lkp_valid_i` is high, and none of them is high otherwise.
- R4: A lookup that matches an entry marked not present raises `fault_o` instead of `hit_o`, and `paddr_o` is zero.
- R5: The flag outputs show the matched entry's flags as they were before the access. A hit sets the entry's recently-used flag, which becomes visible from the next lookup on. A fill clears both the recently-used and modified flags.
- R6: A hit with `lkp_write_i` high sets the entry's modified flag. A hit with `lkp_write_i` low leaves it unchanged.
- R7: A fill whose page number is already held overwrites that entry. Later lookups return the new frame, and no key is ever held twice.
- R8: While an empty slot exists, a fill of a new page uses an empty slot and displaces no valid translation.
- R9: When all slots are full, a fill of a new page displaces exactly one older translation, chosen by a 4-bit pseudo-random pointer that never holds zero.
- R10: A fault or a miss leaves every entry's flags unchanged.
- R11: A flush takes priority over a fill in the same cycle, so the page that was being filled misses afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Empty every entry |
| lkp_valid_i | input | 1 | Lookup strobe |
| lkp_write_i | input | 1 | Lookup is a store access |
| lkp_vaddr_i | input | 20 | Virtual address: page 19:10, offset 9:0 |
| fill_valid_i | input | 1 | Write a translation |
| fill_vpn_i | input | 10 | Page number to write |
| fill_pfn_i | input | 6 | Frame number to write |
| fill_resident_i | input | 1 | Page is present in memory |
| hit_o | output | 1 | Translation found and present |
| miss_o | output | 1 | No entry for the page |
| fault_o | output | 1 | Entry found, page not present |
| paddr_o | output | 16 | Physical address: frame 15:10, offset 9:0 |
| dirty_o | output | 1 | Modified flag of matched entry |
| refd_o | output | 1 | Recently-used flag of matched entry |
| resident_o | output | 1 | Present flag of matched entry |

## Verification
A lost or wrongly set valid bit shows up as a miss or a stale hit on the very next lookup of that page. A duplicated key corrupts the frame mux, so the wrong frame reaches `paddr_o` in the same cycle. Flag updates that land in the wrong slot surface on the next lookup of either page, through the `dirty_o` and `refd_o` outputs. A bad replacement choice shows up as too many or too few surviving translations after a fill into a full buffer, which a sweep of lookups over all the old pages counts right away.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef struct packed {
    logic dirty;
    logic refd;
    logic resident;
  } tlb_flags_t;

  // Feedback masks for maximal-length shift-left Fibonacci LFSRs.
  function automatic logic [31:0] lfsr_taps(input int unsigned width);
    case (width)
      2:       lfsr_taps = 32'h0000_0003;
      3:       lfsr_taps = 32'h0000_0006;
      4:       lfsr_taps = 32'h0000_000C;
      5:       lfsr_taps = 32'h0000_0014;
      6:       lfsr_taps = 32'h0000_0030;
      7:       lfsr_taps = 32'h0000_0060;
      default: lfsr_taps = 32'h0000_00B8;
    endcase
  endfunction

endpackage

// File: rtl/tlb_cam_match.sv
module tlb_cam_match #(
  parameter int ENTRIES = 16,
  parameter int KEY_W   = 10,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [KEY_W-1:0]   keys_i [ENTRIES],
  input  logic [KEY_W-1:0]   probe_i,
  output logic [ENTRIES-1:0] match_o,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);

  // One comparator per entry.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (keys_i[g] == probe_i);
  end

  assign any_o = |match_o;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_o[i]) idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic               dup_hit_i,
  input  logic [IDX_W-1:0]   dup_idx_i,
  output logic [IDX_W-1:0]   victim_o
);

  localparam logic [IDX_W-1:0] TAPS = IDX_W'(lfsr_taps(IDX_W));

  logic [IDX_W-1:0] lfsr_q, lfsr_d;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;

  // Pointer steps every cycle.
  always_comb begin
    lfsr_d = {lfsr_q[IDX_W-2:0], ^(lfsr_q & TAPS)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= IDX_W'(1);
    else        lfsr_q <= lfsr_d;
  end

  // Lowest-numbered empty slot.
  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) free_idx = IDX_W'(i);
    end
  end

  assign any_free = ~&valid_i;

  always_comb begin
    if (dup_hit_i)     victim_o = dup_idx_i;
    else if (any_free) victim_o = free_idx;
    else               victim_o = lfsr_q;
  end

  a_r9_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 10,
  parameter int PFN_W   = 6,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_i,
  input  logic               fill_en_i,
  input  logic [IDX_W-1:0]   fill_idx_i,
  input  logic [VPN_W-1:0]   fill_vpn_i,
  input  logic [PFN_W-1:0]   fill_pfn_i,
  input  logic               fill_resident_i,
  input  logic               upd_en_i,
  input  logic [IDX_W-1:0]   upd_idx_i,
  input  logic               upd_write_i,
  output logic [ENTRIES-1:0] valid_o,
  output logic [VPN_W-1:0]   vpn_o   [ENTRIES],
  output logic [PFN_W-1:0]   pfn_o   [ENTRIES],
  output tlb_flags_t         flags_o [ENTRIES]
);

  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [ENTRIES-1:0] fill_we;
  tlb_flags_t         flags_q [ENTRIES];
  tlb_flags_t         flags_d [ENTRIES];
  logic [VPN_W-1:0]   vpn_q   [ENTRIES];
  logic [PFN_W-1:0]   pfn_q   [ENTRIES];

  // Next state: flush, then fill, then hit update.
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      fill_we[i] = !flush_i && fill_en_i && (fill_idx_i == IDX_W'(i));
      valid_d[i] = valid_q[i];
      flags_d[i] = flags_q[i];
      if (flush_i) begin
        valid_d[i] = 1'b0;
      end else if (fill_we[i]) begin
        valid_d[i]          = 1'b1;
        flags_d[i].dirty    = 1'b0;
        flags_d[i].refd     = 1'b0;
        flags_d[i].resident = fill_resident_i;
      end else if (upd_en_i && (upd_idx_i == IDX_W'(i))) begin
        flags_d[i].refd  = 1'b1;
        flags_d[i].dirty = flags_q[i].dirty | upd_write_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < ENTRIES; i++) flags_q[i] <= '0;
    end else begin
      valid_q <= valid_d;
      for (int i = 0; i < ENTRIES; i++) flags_q[i] <= flags_d[i];
    end
  end

  // Key and frame storage: enabled writes, no reset.
  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (fill_we[i]) begin
        vpn_q[i] <= fill_vpn_i;
        pfn_q[i] <= fill_pfn_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign vpn_o   = vpn_q;
  assign pfn_o   = pfn_q;
  assign flags_o = flags_q;

  a_r1_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> valid_q == '0);

  a_r7_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en_i && !flush_i) |=>
      (valid_q[$past(fill_idx_i)] && vpn_q[$past(fill_idx_i)] == $past(fill_vpn_i)
       && !flags_q[$past(fill_idx_i)].refd));

  a_r6_dirty_set: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en_i && upd_write_i && !flush_i && !(fill_en_i && fill_idx_i == upd_idx_i))
      |=> flags_q[$past(upd_idx_i)].dirty);

  a_r5_ref_set: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en_i && !flush_i && !(fill_en_i && fill_idx_i == upd_idx_i))
      |=> flags_q[$past(upd_idx_i)].refd);

endmodule

// File: rtl/fa_tlb.sv
module fa_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 10,
  parameter int PFN_W   = 6,
  parameter int OFF_W   = 10,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PFN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             lkp_valid_i,
  input  logic             lkp_write_i,
  input  logic [VA_W-1:0]  lkp_vaddr_i,
  input  logic             fill_valid_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PFN_W-1:0] fill_pfn_i,
  input  logic             fill_resident_i,
  output logic             hit_o,
  output logic             miss_o,
  output logic             fault_o,
  output logic [PA_W-1:0]  paddr_o,
  output logic             dirty_o,
  output logic             refd_o,
  output logic             resident_o
);

  logic [ENTRIES-1:0] valid;
  logic [VPN_W-1:0]   vpn   [ENTRIES];
  logic [PFN_W-1:0]   pfn   [ENTRIES];
  tlb_flags_t         flags [ENTRIES];

  logic [VPN_W-1:0]   lkp_vpn;
  logic [OFF_W-1:0]   lkp_off;
  logic [ENTRIES-1:0] lkp_match, fill_match;
  logic               lkp_any, fill_any;
  logic [IDX_W-1:0]   lkp_idx, fill_dup_idx, fill_idx;
  tlb_flags_t         sel_flags;
  logic [PFN_W-1:0]   sel_pfn;
  logic               found;

  assign lkp_vpn = lkp_vaddr_i[VA_W-1:OFF_W];
  assign lkp_off = lkp_vaddr_i[OFF_W-1:0];

  tlb_cam_match #(.ENTRIES(ENTRIES), .KEY_W(VPN_W)) u_lkp_cam (
    .valid_i (valid),
    .keys_i  (vpn),
    .probe_i (lkp_vpn),
    .match_o (lkp_match),
    .any_o   (lkp_any),
    .idx_o   (lkp_idx)
  );

  tlb_cam_match #(.ENTRIES(ENTRIES), .KEY_W(VPN_W)) u_fill_cam (
    .valid_i (valid),
    .keys_i  (vpn),
    .probe_i (fill_vpn_i),
    .match_o (fill_match),
    .any_o   (fill_any),
    .idx_o   (fill_dup_idx)
  );

  tlb_victim_sel #(.ENTRIES(ENTRIES)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (valid),
    .dup_hit_i (fill_any),
    .dup_idx_i (fill_dup_idx),
    .victim_o  (fill_idx)
  );

  tlb_entry_store #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PFN_W   (PFN_W)
  ) u_store (
    .clk             (clk),
    .rst_n           (rst_n),
    .flush_i         (flush_i),
    .fill_en_i       (fill_valid_i),
    .fill_idx_i      (fill_idx),
    .fill_vpn_i      (fill_vpn_i),
    .fill_pfn_i      (fill_pfn_i),
    .fill_resident_i (fill_resident_i),
    .upd_en_i        (hit_o),
    .upd_idx_i       (lkp_idx),
    .upd_write_i     (lkp_write_i),
    .valid_o         (valid),
    .vpn_o           (vpn),
    .pfn_o           (pfn),
    .flags_o         (flags)
  );

  assign sel_flags = flags[lkp_idx];
  assign sel_pfn   = pfn[lkp_idx];
  assign found     = lkp_valid_i && lkp_any;

  always_comb begin
    hit_o      = found && sel_flags.resident;
    fault_o    = found && !sel_flags.resident;
    miss_o     = lkp_valid_i && !lkp_any;
    paddr_o    = hit_o ? {sel_pfn, lkp_off} : '0;
    dirty_o    = found && sel_flags.dirty;
    refd_o     = found && sel_flags.refd;
    resident_o = found && sel_flags.resident;
  end

  a_r7_unique_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lkp_match));

  a_r7_unique_fill: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fill_match));

  a_r3_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({hit_o, miss_o, fault_o}) == (lkp_valid_i ? 1 : 0));

  a_r4_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (paddr_o == '0 && !resident_o));

  a_r8_free_first: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid_i && !flush_i && !fill_any && !(&valid)) |-> !valid[fill_idx]);

endmodule

// File: tb/fa_tlb_tb.sv
`timescale 1ns/1ps
module fa_tlb_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush_i, lkp_valid_i, lkp_write_i;
  logic [19:0] lkp_vaddr_i;
  logic        fill_valid_i;
  logic [9:0]  fill_vpn_i;
  logic [5:0]  fill_pfn_i;
  logic        fill_resident_i;
  logic        hit_o, miss_o, fault_o;
  logic [15:0] paddr_o;
  logic        dirty_o, refd_o, resident_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  fa_tlb u_dut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .lkp_valid_i(lkp_valid_i), .lkp_write_i(lkp_write_i), .lkp_vaddr_i(lkp_vaddr_i),
    .fill_valid_i(fill_valid_i), .fill_vpn_i(fill_vpn_i), .fill_pfn_i(fill_pfn_i),
    .fill_resident_i(fill_resident_i),
    .hit_o(hit_o), .miss_o(miss_o), .fault_o(fault_o), .paddr_o(paddr_o),
    .dirty_o(dirty_o), .refd_o(refd_o), .resident_o(resident_o)
  );

  // op: 0 fill, 1 read lookup, 2 write lookup
  typedef struct packed {
    logic [1:0] op;
    logic [9:0] vpn;
    logic [9:0] off;
    logic [5:0] pfn;
    logic       res;
    logic       ehit, emiss, efault, ed, er;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{2'd1, 10'h005, 10'h03A, 6'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 cold miss
    '{2'd0, 10'h005, 10'h000, 6'h2C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // fill
    '{2'd1, 10'h005, 10'h1A3, 6'h2C, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 hit
    '{2'd2, 10'h005, 10'h000, 6'h2C, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd5},  // R5 ref now seen
    '{2'd1, 10'h005, 10'h3FF, 6'h2C, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd6},  // R6 dirty set
    '{2'd0, 10'h3FF, 10'h000, 6'h3F, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},  // fill non-present
    '{2'd2, 10'h3FF, 10'h155, 6'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 fault
    '{2'd1, 10'h3FF, 10'h2AA, 6'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd10}, // R10 no update
    '{2'd0, 10'h005, 10'h000, 6'h11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // refill same page
    '{2'd1, 10'h005, 10'h001, 6'h11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 new frame
    '{2'd1, 10'h005, 10'h002, 6'h11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6},  // R6 read keeps dirty 0
    '{2'd1, 10'h006, 10'h001, 6'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 miss
    '{2'd0, 10'h000, 10'h000, 6'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // fill page 0
    '{2'd1, 10'h000, 10'h000, 6'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2}   // R2 zero page
  };

  task automatic idle_inputs();
    flush_i = 0; lkp_valid_i = 0; lkp_write_i = 0; lkp_vaddr_i = '0;
    fill_valid_i = 0; fill_vpn_i = '0; fill_pfn_i = '0; fill_resident_i = 0;
  endtask

  task automatic do_fill(input logic [9:0] vpn, input logic [5:0] pfn, input logic res,
                         input logic flush);
    @(negedge clk);
    fill_valid_i = 1; fill_vpn_i = vpn; fill_pfn_i = pfn; fill_resident_i = res;
    flush_i = flush;
    @(posedge clk); #1;
    idle_inputs();
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush_i = 1;
    @(posedge clk); #1;
    idle_inputs();
  endtask

  // Drives one lookup, compares all outputs in the same cycle.
  task automatic check_lookup(input string tag, input logic wr, input logic [9:0] vpn,
                              input logic [9:0] off, input logic ehit, input logic emiss,
                              input logic efault, input logic [5:0] epfn,
                              input logic ed, input logic er);
    logic [21:0] act, exp;
    @(negedge clk);
    lkp_valid_i = 1; lkp_write_i = wr; lkp_vaddr_i = {vpn, off};
    #1;
    act = {hit_o, miss_o, fault_o, paddr_o, dirty_o, refd_o, resident_o};
    exp = {ehit, emiss, efault, (ehit ? {epfn, off} : 16'h0000), ed, er, ehit};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s vpn=%h act=%h exp=%h", tag, vpn, act, exp);
    end
    @(posedge clk); #1;
    idle_inputs();
  endtask

  task automatic probe_hit(input logic [9:0] vpn, output logic h);
    @(negedge clk);
    lkp_valid_i = 1; lkp_vaddr_i = {vpn, 10'h000};
    #1;
    h = hit_o;
    @(posedge clk); #1;
    idle_inputs();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int survivors;
    logic h;
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1 reset state: idle outputs all zero, any lookup misses
    #1;
    checks++;
    if ({hit_o, miss_o, fault_o, paddr_o, dirty_o, refd_o, resident_o} !== 22'h0) begin
      fails++;
      $display("FAIL R1 idle outputs act=%b exp=0", {hit_o, miss_o, fault_o, paddr_o});
    end
    check_lookup("R1 after reset", 0, 10'h123, 10'h045, 0, 1, 0, 6'h00, 0, 0);

    // Vector table
    for (int k = 0; k < NV; k++) begin
      if (TBL[k].op == 2'd0)
        do_fill(TBL[k].vpn, TBL[k].pfn, TBL[k].res, 1'b0);
      else
        check_lookup($sformatf("R%0d vec%0d", TBL[k].req, k), TBL[k].op == 2'd2,
                     TBL[k].vpn, TBL[k].off, TBL[k].ehit, TBL[k].emiss, TBL[k].efault,
                     TBL[k].pfn, TBL[k].ed, TBL[k].er);
    end

    // R1 flush empties everything
    do_flush();
    check_lookup("R1 flush", 0, 10'h005, 10'h001, 0, 1, 0, 6'h00, 0, 0);
    check_lookup("R1 flush page0", 0, 10'h000, 10'h001, 0, 1, 0, 6'h00, 0, 0);

    // R11 flush beats a same-cycle fill
    do_fill(10'h0AA, 6'h15, 1'b1, 1'b1);
    check_lookup("R11 flush priority", 0, 10'h0AA, 10'h000, 0, 1, 0, 6'h00, 0, 0);

    // R8 sixteen distinct fills all survive
    for (int i = 0; i < 16; i++) do_fill(10'h100 + 10'(i), 6'(i + 32), 1'b1, 1'b0);
    for (int i = 0; i < 16; i++)
      check_lookup("R8 full set", 0, 10'h100 + 10'(i), 10'(i * 7), 1, 0, 0, 6'(i + 32), 0, 0);

    // R9 a new page into a full buffer displaces exactly one
    do_fill(10'h200, 6'h2A, 1'b1, 1'b0);
    check_lookup("R9 new page", 0, 10'h200, 10'h333, 1, 0, 0, 6'h2A, 0, 0);
    survivors = 0;
    for (int i = 0; i < 16; i++) begin
      probe_hit(10'h100 + 10'(i), h);
      if (h) survivors++;
    end
    checks++;
    if (survivors != 15) begin
      fails++;
      $display("FAIL R9 survivors act=%0d exp=15", survivors);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule